// File: doc/BRIEF.md
# Windowed Fixed-Rate Sample Framer

The block paces an external 8-bit converter from the system clock. It issues a one-cycle sample request at a fixed count of clock cycles, for example every 2000 cycles, which gives 8 kHz from 16 MHz. When the converter answers with a valid unsigned sample, the block removes a constant DC offset and applies a trapezoidal window weight that depends on the sample's slot in the frame. It then scales the result into a signed 16-bit word and writes it into a frame buffer.

When every slot of the frame has been written, the block flags the frame as ready and stops requesting samples. A downstream transform engine reads the words through a registered read port and then acknowledges the frame. The block then starts filling again from slot 0 and overwrites the old contents. Request ticks that fall while a full frame is waiting produce no request. Each such tick is counted in a saturating overrun counter, so missed sample times remain visible.

Top module: `sampleFramer`

## Requirements
- R1: While no full frame waits, `sampleReq` pulses high for exactly one cycle every TICK_CYCLES cycles. The first pulse is high in the cycle after the TICK_CYCLES-th rising edge following reset release.
- R2: A sample is accepted only in a cycle where `sampleValid` is high and a request is outstanding. A request is outstanding from the cycle `sampleReq` is high until one sample has been accepted. A `sampleValid` at any other time is ignored and does not advance the write slot.
- R3: The accepted sample d in slot k (0-based) is stored as the 16-bit two's complement word ((d − 140) · w >>> 5) << 4, where >>> is an arithmetic shift that rounds toward minus infinity. The weight w is k+1 for k < 32, 128−k for k ≥ 96, and 32 otherwise.
- R4: The sign survives the scaling. In the flat region, sample 0 stores −2240 (0xF740) and sample 255 stores 1840 (0x0730).
- R5: After the 128th accepted sample, `frameReady` is high at the next cycle and stays high until `frameAck` is seen high. It is low in the cycle after that acknowledgement. A `frameAck` while `frameReady` is low has no effect.
- R6: A request tick that falls while `frameReady` is high issues no `sampleReq` and increments `overrunCount` by one. The counter saturates at 2^OVR_W − 1.
- R7: After an acknowledgement, the next accepted sample is written to slot 0 and later samples follow in order, overwriting the previous frame.
- R8: `rdData` holds the word stored at the `rdAddr` presented one clock edge earlier.
- R9: After reset, `sampleReq` and `frameReady` are low, `overrunCount` is 0, and the write slot is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleReq | output | 1 | One-cycle strobe asking the converter for a sample |
| sampleValid | input | 1 | Converter result valid |
| sampleData | input | 8 | Unsigned converter result |
| rdAddr | input | 7 | Frame buffer read slot |
| rdData | output | 16 | Stored signed word, one cycle after rdAddr |
| frameReady | output | 1 | Full frame waiting for the consumer |
| frameAck | input | 1 | Consumer releases the frame |
| overrunCount | output | 8 | Saturating count of ticks lost while a frame waited |

## Verification
The bench builds the block with TICK_CYCLES = 20 and OVR_W = 4. The frame length and ramp length keep their defaults of 128 and 32. The short tick lets two full frames fit easily within the cycle budget, so every slot can be read back for both ramps and the flat region. The narrow counter lets the overrun count reach saturation after about fifteen lost ticks. One frame uses alternating 0 and 255 samples to exercise both signed extremes.

// File: rtl/sampleFramerPkg.sv
package sampleFramerPkg;
  typedef struct packed {
    logic wrEn;    // accept the sample on the data inputs
    logic rewind;  // frame released, restart at slot 0
  } ctrlStrobes_t;
endpackage

// File: rtl/sampleFramerCtrl.sv
module sampleFramerCtrl
  import sampleFramerPkg::*;
#(
  parameter int TICK_CYCLES = 2000,
  parameter int OVR_W       = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sampleValid,
  input  logic             frameAck,
  input  logic             lastSlot,
  output logic             sampleReq,
  output logic             frameReady,
  output logic [OVR_W-1:0] overrunCount,
  output ctrlStrobes_t     strobes
);
  localparam int CNT_W = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TICK_CYCLES - 1);
  localparam logic [OVR_W-1:0] OVR_MAX = '1;

  logic [CNT_W-1:0] tickCnt;
  logic             tick;
  logic             pending;

  assign tick = (tickCnt == CNT_LAST);

  always_comb begin
    strobes.wrEn   = sampleValid && pending && !frameReady;
    strobes.rewind = frameReady && frameAck;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tickCnt      <= '0;
      sampleReq    <= 1'b0;
      pending      <= 1'b0;
      frameReady   <= 1'b0;
      overrunCount <= '0;
    end else begin
      tickCnt   <= tick ? '0 : tickCnt + 1'b1;
      sampleReq <= tick && !frameReady;

      if (tick && !frameReady)
        pending <= 1'b1;
      else if (strobes.wrEn)
        pending <= 1'b0;

      if (strobes.rewind)
        frameReady <= 1'b0;
      else if (strobes.wrEn && lastSlot)
        frameReady <= 1'b1;

      if (tick && frameReady && overrunCount != OVR_MAX)
        overrunCount <= overrunCount + 1'b1;
    end
  end
endmodule

// File: rtl/sampleFramerData.sv
module sampleFramerData
  import sampleFramerPkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int WORD_W    = 16,
  parameter int FRAME_LEN = 128,
  parameter int RAMP_LEN  = 32,
  parameter int DC_OFFSET = 140,
  parameter int SCALE_SH  = 4
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  ctrlStrobes_t                 strobes,
  input  logic [DATA_W-1:0]            sampleData,
  input  logic [$clog2(FRAME_LEN)-1:0] rdAddr,
  output logic [WORD_W-1:0]            rdData,
  output logic                         lastSlot
);
  localparam int IDX_W   = $clog2(FRAME_LEN);
  localparam int RAMP_SH = $clog2(RAMP_LEN);
  localparam int WGT_W   = RAMP_SH + 1;
  localparam int PROD_W  = DATA_W + 1 + WGT_W + 1;
  localparam logic [DATA_W:0] DC_VAL = (DATA_W+1)'(DC_OFFSET);
  localparam logic [IDX_W:0] RAMP_UP_END  = (IDX_W+1)'(RAMP_LEN);
  localparam logic [IDX_W:0] RAMP_DN_BEG  = (IDX_W+1)'(FRAME_LEN - RAMP_LEN);
  localparam logic [IDX_W:0] FRAME_SIZE   = (IDX_W+1)'(FRAME_LEN);

  logic [IDX_W-1:0]         wrIdx;
  logic [IDX_W:0]           idxExt;
  logic [IDX_W:0]           wRaw;
  logic [WGT_W-1:0]         weight;
  logic signed [DATA_W:0]   centered;
  logic signed [PROD_W-1:0] prod;
  logic signed [PROD_W-1:0] shifted;
  logic signed [WORD_W-1:0] widened;
  logic [WORD_W-1:0]        word;
  logic [WORD_W-1:0]        frameMem [FRAME_LEN];

  assign lastSlot = (wrIdx == IDX_W'(FRAME_LEN - 1));

  always_comb begin
    idxExt = {1'b0, wrIdx};
    if (idxExt < RAMP_UP_END)
      wRaw = idxExt + 1'b1;
    else if (idxExt >= RAMP_DN_BEG)
      wRaw = FRAME_SIZE - idxExt;
    else
      wRaw = RAMP_UP_END;
    weight   = WGT_W'(wRaw);
    centered = $signed({1'b0, sampleData}) - $signed(DC_VAL);
    prod     = centered * $signed({1'b0, weight});
    shifted  = prod >>> RAMP_SH;
    widened  = WORD_W'(shifted);
    word     = widened <<< SCALE_SH;
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      wrIdx <= '0;
    else if (strobes.rewind)
      wrIdx <= '0;
    else if (strobes.wrEn)
      wrIdx <= lastSlot ? '0 : wrIdx + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (strobes.wrEn)
      frameMem[wrIdx] <= word;
    rdData <= frameMem[rdAddr];
  end
endmodule

// File: rtl/sampleFramer.sv
module sampleFramer
  import sampleFramerPkg::*;
#(
  parameter int TICK_CYCLES = 2000,
  parameter int DATA_W      = 8,
  parameter int WORD_W      = 16,
  parameter int FRAME_LEN   = 128,
  parameter int RAMP_LEN    = 32,
  parameter int DC_OFFSET   = 140,
  parameter int SCALE_SH    = 4,
  parameter int OVR_W       = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  output logic                         sampleReq,
  input  logic                         sampleValid,
  input  logic [DATA_W-1:0]            sampleData,
  input  logic [$clog2(FRAME_LEN)-1:0] rdAddr,
  output logic [WORD_W-1:0]            rdData,
  output logic                         frameReady,
  input  logic                         frameAck,
  output logic [OVR_W-1:0]             overrunCount
);
  ctrlStrobes_t strobes;
  logic         lastSlot;

  sampleFramerCtrl #(
    .TICK_CYCLES(TICK_CYCLES),
    .OVR_W      (OVR_W)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .sampleValid (sampleValid),
    .frameAck    (frameAck),
    .lastSlot    (lastSlot),
    .sampleReq   (sampleReq),
    .frameReady  (frameReady),
    .overrunCount(overrunCount),
    .strobes     (strobes)
  );

  sampleFramerData #(
    .DATA_W   (DATA_W),
    .WORD_W   (WORD_W),
    .FRAME_LEN(FRAME_LEN),
    .RAMP_LEN (RAMP_LEN),
    .DC_OFFSET(DC_OFFSET),
    .SCALE_SH (SCALE_SH)
  ) u_data (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .sampleData(sampleData),
    .rdAddr    (rdAddr),
    .rdData    (rdData),
    .lastSlot  (lastSlot)
  );
endmodule

// File: rtl/sampleFramerChk.sv
module sampleFramerChk #(
  parameter int OVR_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             sampleReq,
  input logic             frameReady,
  input logic             frameAck,
  input logic [OVR_W-1:0] overrunCount
);
  localparam logic [OVR_W-1:0] OVR_MAX = '1;

  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    sampleReq |=> !sampleReq); // R1
  AST_NO_REQ_WHILE_FULL: assert property (@(posedge clk) disable iff (!rstN)
    $past(frameReady) |-> !sampleReq); // R6
  AST_READY_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (frameReady && !frameAck) |=> frameReady); // R5
  AST_ACK_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    (frameReady && frameAck) |=> !frameReady); // R5
  AST_OVR_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !frameReady |=> $stable(overrunCount)); // R6
  AST_OVR_SATURATE: assert property (@(posedge clk) disable iff (!rstN)
    (overrunCount == OVR_MAX) |=> (overrunCount == OVR_MAX)); // R6
endmodule

bind sampleFramer sampleFramerChk #(.OVR_W(OVR_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .sampleReq   (sampleReq),
  .frameReady  (frameReady),
  .frameAck    (frameAck),
  .overrunCount(overrunCount)
);

// File: tb/test_sampleFramer.sv
`timescale 1ns/1ps
module test_sampleFramer;
  localparam int TICK  = 20;
  localparam int FLEN  = 128;
  localparam int OVRW  = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sampleReq;
  logic        sampleValid = 1'b0;
  logic [7:0]  sampleData = '0;
  logic [6:0]  rdAddr = '0;
  logic [15:0] rdData;
  logic        frameReady;
  logic        frameAck = 1'b0;
  logic [OVRW-1:0] overrunCount;

  int checks = 0;
  int fails = 0;
  int cycle = 0;
  bit sawReqWhileFull = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cycle <= cycle + 1;
  always @(negedge clk) if (frameReady && sampleReq) sawReqWhileFull = 1'b1;

  sampleFramer #(.TICK_CYCLES(TICK), .OVR_W(OVRW)) i_sampleFramer (
    .clk(clk), .rstN(rstN), .sampleReq(sampleReq), .sampleValid(sampleValid),
    .sampleData(sampleData), .rdAddr(rdAddr), .rdData(rdData),
    .frameReady(frameReady), .frameAck(frameAck), .overrunCount(overrunCount)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int patData(input int pat, input int i);
    if (pat == 0) return (i * 37 + 11) % 256;
    return (i % 2 == 0) ? 0 : 255;
  endfunction

  function automatic int expWord(input int k, input int d);
    int c, w, p;
    c = d - 140;
    if (k < 32) w = k + 1;
    else if (k >= 96) w = 128 - k;
    else w = 32;
    p = (c * w) >>> 5;
    return p * 16;
  endfunction

  task automatic waitReq(output int at);
    int guard = 0;
    do begin
      @(negedge clk);
      guard++;
    end while (!sampleReq && guard < 4 * TICK);
    at = cycle;
  endtask

  task automatic checkReset();
    check(sampleReq == 1'b0, "R9 sampleReq", int'(sampleReq), 0);
    check(frameReady == 1'b0, "R9 frameReady", int'(frameReady), 0);
    check(overrunCount == 0, "R9 overrunCount", int'(overrunCount), 0);
  endtask

  // Fill one frame; spurious valids and a premature ack are injected on the way.
  task automatic captureFrame(input int pat, input bit checkPeriod);
    int at, prevAt;
    prevAt = -1;
    for (int i = 0; i < FLEN; i++) begin
      waitReq(at);
      if (checkPeriod && prevAt >= 0 && i < 6)
        check(at - prevAt == TICK, "R1 request period", at - prevAt, TICK);
      prevAt = at;
      sampleValid = 1'b1;
      sampleData  = 8'(patData(pat, i));
      @(negedge clk);
      // R2: no request outstanding now, this junk must be ignored
      sampleValid = (i % 16 == 3);
      sampleData  = 8'hA5;
      if (i == 50) frameAck = 1'b1; // R5: ack without a ready frame
      @(negedge clk);
      sampleValid = 1'b0;
      frameAck    = 1'b0;
      if (i == FLEN - 2)
        check(frameReady == 1'b0, "R5 not ready before last sample", int'(frameReady), 0);
    end
    check(frameReady == 1'b1, "R5 ready after last sample", int'(frameReady), 1);
  endtask

  task automatic checkFrame(input int pat, input string req);
    for (int k = 0; k < FLEN; k++) begin
      rdAddr = 7'(k);
      @(negedge clk);
      check($signed(rdData) == expWord(k, patData(pat, k)), req,
            int'($signed(rdData)), expWord(k, patData(pat, k)));
    end
  endtask

  task automatic checkExtremes();
    rdAddr = 7'd64;
    @(negedge clk);
    check($signed(rdData) == -2240, "R4 negative extreme", int'($signed(rdData)), -2240);
    rdAddr = 7'd65;
    @(negedge clk);
    check($signed(rdData) == 1840, "R4 positive extreme", int'($signed(rdData)), 1840);
  endtask

  task automatic checkOverrun();
    int v0;
    sawReqWhileFull = 1'b0;
    v0 = int'(overrunCount);
    repeat (3 * TICK) @(negedge clk);
    check(int'(overrunCount) == v0 + 3, "R6 overrun counts ticks", int'(overrunCount), v0 + 3);
    repeat (20 * TICK) @(negedge clk);
    check(overrunCount == 4'hF, "R6 overrun saturates", int'(overrunCount), 15);
    check(sawReqWhileFull == 1'b0, "R6 no request while full", int'(sawReqWhileFull), 0);
    check(frameReady == 1'b1, "R5 ready held without ack", int'(frameReady), 1);
  endtask

  task automatic ackFrame();
    frameAck = 1'b1;
    @(negedge clk);
    frameAck = 1'b0;
    check(frameReady == 1'b0, "R5 ack releases frame", int'(frameReady), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checkReset();
    rstN = 1'b1;
    captureFrame(0, 1'b1);
    checkFrame(0, "R3 window frame 0, R8 read");
    checkOverrun();
    ackFrame();
    captureFrame(1, 1'b0);
    checkFrame(1, "R7 rewritten frame from slot 0");
    checkExtremes();
    check(overrunCount == 4'hF, "R6 saturated count kept", int'(overrunCount), 15);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule